// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial port that drives its own serial clock. Each transfer moves one 8-bit frame out on the data-out line while another 8-bit frame is taken in from the data-in line. The serial clock comes from the system clock through a programmable divider. Software reaches the block through a small write port and a receive-read strobe. Through these it sets the operating mode, the two enables, the clock polarity, the bit order and an optional data inversion, and it loads the transmit buffer.

The mode field has two defined values: off (000b) and synchronous (001b). Any write that leaves the mode at a value other than synchronous stops a frame in flight and empties every buffer and flag. Software recovers an interrupted transfer by writing off and then synchronous. The polarity bit selects the clock idle level, the launch edge and the capture edge together. A change to it is not applied while a frame is running.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the mode is off, the serial clock is high, the data-out line is high, tx_ready is 1, and rx_full, rx_overrun and busy are 0.
- R2: A frame starts only when the mode is synchronous, both enables are set and the transmit buffer holds data. At the start tx_ready returns to 1. The control byte at address 0 holds mode in bits 2:0, transmit enable in bit 3, receive enable in bit 4, polarity in bit 5, bit order in bit 6 and inversion in bit 7.
- R3: With polarity 0 the clock idles high, data-out changes on falling edges and data-in is sampled on rising edges. With polarity 1 all of these are reversed. A frame has exactly 16 clock edges and ends at the idle level.
- R4: The divider byte at address 1 sets a half bit period of divider+1 system clocks, so busy stays high for 16*(divider+1) cycles.
- R5: Bit order 0 sends and receives bit 0 first. Bit order 1 sends and receives bit 7 first.
- R6: Inversion 1 inverts the line level of both sent and received data. Inversion 0 leaves the data as it is.
- R7: When a frame ends, the received byte appears on rx_data and rx_full is set. A pulse on rx_rd clears rx_full.
- R8: If a frame ends while rx_full is still set, rx_overrun is set and rx_data takes the new byte. A pulse on rx_rd clears rx_overrun.
- R9: A control write whose mode is not synchronous aborts any frame. The clock returns to idle, busy drops, the transmit buffer is emptied and rx_full and rx_overrun are cleared. Writes to the buffer at address 2 are dropped until the mode is synchronous again. The next frame after that is sent and received correctly.
- R10: A polarity change written during a frame does not affect that frame. The next control write made while idle applies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 divider, 2 transmit buffer |
| reg_wdata | input | 8 | Register write data |
| rx_rd | input | 1 | Receive buffer read pulse |
| rxd | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock out |
| txd | output | 1 | Serial data out |
| tx_ready | output | 1 | Transmit buffer empty |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_overrun | output | 1 | A byte arrived while the buffer was still full |
| busy | output | 1 | Frame in progress |
| rx_data | output | 8 | Receive buffer contents |

## Verification
A wrong bit counter shows as an edge count other than 16 on the serial clock, and a wrong divider count shows as a wrong busy length. Both are visible when the first frame ends. A wrong shift direction or a wrong inversion state corrupts the first data bit seen on data-out and the byte in rx_data after one frame. A polarity latch that follows a mid-frame write flips the clock level at once. Abort faults leave busy, tx_ready or rx_full wrong in the cycle after the disabling write.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int REG_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [2:0] MODE_OFF  = 3'b000;
    localparam logic [2:0] MODE_SYNC = 3'b001;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIV   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_TXBUF = 2'd2;

    typedef struct packed {
        logic       inv;
        logic       msb_first;
        logic       pol;
        logic       rx_en;
        logic       tx_en;
        logic [2:0] mode;
    } ctrl_t;
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_t;

    baud_t q, d;

    always_comb begin
        d    = q;
        tick = run && (q.cnt == div);
        if (!run || tick) d.cnt = '0;
        else              d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sio_shift.sv
module sio_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              launch,
    input  logic              capture,
    input  logic              msb_first,
    input  logic              invert,
    input  logic              rxd,
    output logic              txd,
    output logic [DATA_W-1:0] rx_word_next
);
    typedef struct packed {
        logic [DATA_W-1:0] tsh;
        logic [DATA_W-1:0] rsh;
        logic              txd;
    } shift_t;

    shift_t q, d;
    logic   rx_bit;

    always_comb begin
        d      = q;
        rx_bit = rxd ^ invert;
        rx_word_next = msb_first ? {q.rsh[DATA_W-2:0], rx_bit}
                                 : {rx_bit, q.rsh[DATA_W-1:1]};
        if (load) begin
            d.tsh = load_word;
            d.rsh = '0;
        end else if (launch) begin
            d.txd = (msb_first ? q.tsh[DATA_W-1] : q.tsh[0]) ^ invert;
            d.tsh = msb_first ? (q.tsh << 1) : (q.tsh >> 1);
        end else if (capture) begin
            d.rsh = rx_word_next;
        end
        if (clear) begin
            d.tsh = '0;
            d.rsh = '0;
            d.txd = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{tsh: '0, rsh: '0, txd: 1'b1};
        else        q <= d;
    end

    assign txd = q.txd;
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import sio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              rx_rd,
    input  logic              rxd,
    output logic              sclk,
    output logic              txd,
    output logic              tx_ready,
    output logic              rx_full,
    output logic              rx_overrun,
    output logic              busy,
    output logic [DATA_W-1:0] rx_data
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DIV_W-1:0]  div;
        logic              pol_act;
        logic              frm_msb;
        logic              frm_inv;
        logic [DATA_W-1:0] tx_buf;
        logic              tx_full;
        logic [DATA_W-1:0] rx_buf;
        logic              rx_full;
        logic              ovr;
        logic              busy;
        logic              phase;
        logic [CNT_W-1:0]  bitcnt;
        logic              sclk;
    } state_t;

    state_t q, d;

    logic              tick;
    logic              start;
    logic              abort;
    logic              launch;
    logic              capture;
    logic              sync_on;
    logic [DATA_W-1:0] rx_word_next;
    ctrl_t             wctrl;

    // signals brought out for the bound checker
    logic              pol_act_w;
    logic [2:0]        mode_w;
    logic              tx_en_w;
    logic              rx_en_w;

    assign sync_on = (q.ctrl.mode == MODE_SYNC);
    assign wctrl   = ctrl_t'(reg_wdata);
    assign launch  = q.busy && tick && !q.phase;
    assign capture = q.busy && tick && q.phase;

    sio_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.busy),
        .div  (q.div),
        .tick (tick)
    );

    sio_shift #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (abort),
        .load        (start),
        .load_word   (q.tx_buf),
        .launch      (launch),
        .capture     (capture),
        .msb_first   (q.frm_msb),
        .invert      (q.frm_inv),
        .rxd         (rxd),
        .txd         (txd),
        .rx_word_next(rx_word_next)
    );

    always_comb begin
        d     = q;
        start = 1'b0;
        abort = 1'b0;

        if (rx_rd) begin
            d.rx_full = 1'b0;
            d.ovr     = 1'b0;
        end

        // half-period sequencing: idle-level half then active-level half
        if (q.busy && tick) begin
            if (!q.phase) begin
                d.phase = 1'b1;
            end else begin
                d.phase = 1'b0;
                if (q.bitcnt == LAST_BIT) begin
                    d.busy   = 1'b0;
                    d.bitcnt = '0;
                    d.rx_buf = rx_word_next;
                    if (d.rx_full) d.ovr = 1'b1;
                    d.rx_full = 1'b1;
                end else begin
                    d.bitcnt = q.bitcnt + 1'b1;
                end
            end
        end

        if (!q.busy && sync_on && q.ctrl.tx_en && q.ctrl.rx_en && q.tx_full) begin
            start     = 1'b1;
            d.busy    = 1'b1;
            d.phase   = 1'b0;
            d.bitcnt  = '0;
            d.tx_full = 1'b0;
            d.frm_msb = q.ctrl.msb_first;
            d.frm_inv = q.ctrl.inv;
        end

        if (reg_wr && reg_addr == ADDR_TXBUF && sync_on) begin
            d.tx_buf  = reg_wdata[DATA_W-1:0];
            d.tx_full = 1'b1;
        end

        if (reg_wr && reg_addr == ADDR_DIV) begin
            d.div = reg_wdata[DIV_W-1:0];
        end

        if (reg_wr && reg_addr == ADDR_CTRL) begin
            d.ctrl = wctrl;
            if (!q.busy || wctrl.mode != MODE_SYNC) d.pol_act = wctrl.pol;
            if (wctrl.mode != MODE_SYNC) abort = 1'b1;
        end

        if (abort) begin
            d.busy    = 1'b0;
            d.phase   = 1'b0;
            d.bitcnt  = '0;
            d.tx_full = 1'b0;
            d.rx_full = 1'b0;
            d.ovr     = 1'b0;
        end

        d.sclk = (d.busy && d.phase) ? d.pol_act : ~d.pol_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk       = q.sclk;
    assign tx_ready   = ~q.tx_full;
    assign rx_full    = q.rx_full;
    assign rx_overrun = q.ovr;
    assign busy       = q.busy;
    assign rx_data    = q.rx_buf;

    assign pol_act_w = q.pol_act;
    assign mode_w    = q.ctrl.mode;
    assign tx_en_w   = q.ctrl.tx_en;
    assign rx_en_w   = q.ctrl.rx_en;
endmodule

// File: rtl/sio_checker.sv
module sio_checker
    import sio_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       sclk,
    input logic       tx_ready,
    input logic       rx_full,
    input logic       rx_overrun,
    input logic       pol_act,
    input logic [2:0] mode,
    input logic       tx_en,
    input logic       rx_en
);
    AST_IDLE_CLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == !pol_act)); // R3

    AST_START_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!tx_ready)); // R2

    AST_START_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tx_en && rx_en && mode == MODE_SYNC)); // R2

    AST_DONE_FILLS_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && mode == MODE_SYNC) |-> rx_full); // R7

    AST_OVR_IMPLIES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> rx_full); // R8

    AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_SYNC) |-> (!busy && !rx_full && tx_ready)); // R9

    AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pol_act)); // R10
endmodule

bind sync_serial_xcvr sio_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .sclk      (sclk),
    .tx_ready  (tx_ready),
    .rx_full   (rx_full),
    .rx_overrun(rx_overrun),
    .pol_act   (pol_act_w),
    .mode      (mode_w),
    .tx_en     (tx_en_w),
    .rx_en     (rx_en_w)
);

// File: tb/sync_serial_xcvr_bench.sv
module sync_serial_xcvr_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    // {pol, msb_first, inv, div, tx byte, slave rx byte}
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 8'd0, 8'hA5, 8'h3C},
        {1'b1, 1'b0, 1'b0, 8'd2, 8'h81, 8'h7E},
        {1'b0, 1'b1, 1'b0, 8'd1, 8'h0F, 8'hC3},
        {1'b1, 1'b1, 1'b1, 8'd3, 8'h5A, 8'h96},
        {1'b0, 1'b0, 1'b1, 8'd5, 8'hFF, 8'h00},
        {1'b1, 1'b1, 1'b0, 8'd0, 8'h01, 8'h80}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       rx_rd = 1'b0;
    logic       rxd = 1'b1;
    logic       sclk, txd, tx_ready, rx_full, rx_overrun, busy;
    logic [7:0] rx_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // slave model state
    logic       m_pol = 1'b0;
    logic       m_msb = 1'b0;
    logic       m_inv = 1'b0;
    logic [7:0] m_byte = '0;
    int         m_launch = 0;
    int         m_cap = 0;
    int         edges = 0;
    logic [7:0] cap_line = '0;
    int         busy_cnt = 0;

    sync_serial_xcvr u_sync_serial_xcvr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rx_rd(rx_rd), .rxd(rxd), .sclk(sclk), .txd(txd),
        .tx_ready(tx_ready), .rx_full(rx_full), .rx_overrun(rx_overrun),
        .busy(busy), .rx_data(rx_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (busy) busy_cnt++;

    always @(sclk) begin
        edges++;
        if (sclk === m_pol) begin
            if (m_launch < 8)
                rxd <= (m_msb ? m_byte[7 - m_launch] : m_byte[m_launch]) ^ m_inv;
            m_launch++;
        end else begin
            if (m_cap < 8) cap_line[m_cap] = txd;
            m_cap++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cfg(input logic pol, input logic msb, input logic inv,
                       input logic txe, input logic rxe, input logic [2:0] mode);
        reg_write(2'd0, {inv, msb, pol, rxe, txe, mode});
    endtask

    task automatic read_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic arm_slave(input logic pol, input logic msb, input logic inv,
                             input logic [7:0] b);
        m_pol = pol; m_msb = msb; m_inv = inv; m_byte = b;
        m_launch = 0; m_cap = 0; edges = 0; cap_line = '0; busy_cnt = 0;
    endtask

    task automatic wait_frame();
        for (int i = 0; i < 200 && !busy; i++) @(negedge clk);
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] decode(input logic [7:0] line, input logic msb,
                                          input logic inv);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (msb) r[7 - i] = line[i] ^ inv;
            else     r[i]     = line[i] ^ inv;
        end
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 sclk", sclk, 1);
        check("R1 txd", txd, 1);
        check("R1 tx_ready", tx_ready, 1);
        check("R1 rx_full", rx_full, 0);
        check("R1 busy", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // vector table walk
        for (int v = 0; v < NVEC; v++) begin
            logic p, o, n;
            logic [7:0] dv, tb, rb;
            {p, o, n, dv, tb, rb} = VEC[v];
            cfg(p, o, n, 1'b1, 1'b1, 3'b001);
            reg_write(2'd1, dv);
            arm_slave(p, o, n, rb);
            reg_write(2'd2, tb);
            wait_frame();
            check("R4 busy length", busy_cnt, 16 * (int'(dv) + 1));
            check("R3 edge count", edges, 16);
            check("R3 idle level", sclk, !p);
            check("R5 R6 tx data", decode(cap_line, o, n), tb);
            check("R7 rx data", rx_data, rb);
            check("R7 rx_full set", rx_full, 1);
            read_rx();
            check("R7 rx_full cleared", rx_full, 0);
        end

        // R2: no start without transmit enable
        cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001);
        reg_write(2'd1, 8'd1);
        arm_slave(1'b0, 1'b0, 1'b0, 8'h55);
        reg_write(2'd2, 8'h33);
        repeat (50) @(negedge clk);
        check("R2 held without enable", busy, 0);
        check("R2 buffer kept", tx_ready, 0);
        cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001);
        @(negedge clk);
        check("R2 tx_ready after start", tx_ready, 1);
        wait_frame();
        check("R2 frame after enable", rx_data, 8'h55);
        check("R2 tx after enable", decode(cap_line, 1'b0, 1'b0), 8'h33);

        // R8: overrun when not read
        arm_slave(1'b0, 1'b0, 1'b0, 8'h6B);
        reg_write(2'd2, 8'h11);
        wait_frame();
        check("R8 overrun set", rx_overrun, 1);
        check("R8 newest byte", rx_data, 8'h6B);
        read_rx();
        check("R8 overrun cleared", rx_overrun, 0);
        check("R8 full cleared", rx_full, 0);

        // R9: abort mid-frame, then clean restart
        reg_write(2'd1, 8'd20);
        arm_slave(1'b0, 1'b0, 1'b0, 8'hE7);
        reg_write(2'd2, 8'hC8);
        repeat (100) @(negedge clk);
        check("R9 frame running", busy, 1);
        cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001);
        cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000);
        check("R9 busy dropped", busy, 0);
        check("R9 clock idle", sclk, 1);
        check("R9 tx buffer empty", tx_ready, 1);
        check("R9 rx_full clear", rx_full, 0);
        reg_write(2'd2, 8'h99);
        check("R9 write dropped while off", tx_ready, 1);
        cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001);
        reg_write(2'd1, 8'd1);
        arm_slave(1'b0, 1'b0, 1'b0, 8'h4D);
        reg_write(2'd2, 8'hB2);
        wait_frame();
        check("R9 restart rx", rx_data, 8'h4D);
        check("R9 restart tx", decode(cap_line, 1'b0, 1'b0), 8'hB2);
        check("R9 restart edges", edges, 16);
        read_rx();

        // R10: polarity change during a frame is deferred
        reg_write(2'd1, 8'd10);
        arm_slave(1'b0, 1'b0, 1'b0, 8'h2A);
        reg_write(2'd2, 8'hD4);
        repeat (30) @(negedge clk);
        cfg(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001);
        wait_frame();
        check("R10 edges unchanged", edges, 16);
        check("R10 rx unchanged", rx_data, 8'h2A);
        check("R10 tx unchanged", decode(cap_line, 1'b0, 1'b0), 8'hD4);
        check("R10 idle level kept", sclk, 1);
        cfg(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001);
        check("R10 applied when idle", sclk, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule